// File: doc/BRIEF.md
# Start-Bit Framed Channel Configuration Receiver

This block receives channel configuration bytes on the control port of a multichannel converter. The port has an active-low select, a serial clock and a serial data line. All three are sampled by the block's own clock and are assumed to be synchronous to it. While the select is low, the receiver ignores zero bits until it sees a one. That one bit opens an eight-bit configuration byte, which is shifted in most significant bit first on rising serial-clock edges.

Once the byte is complete, the receiver decodes it into a channel number, a single-ended/differential flag and a three-bit range code. It writes them into a per-channel table that the rest of the converter reads over flat output vectors. An invalid flag is raised for any range code that has no meaning in the chosen mode. A differential setting always lands on the even channel of its pair and marks the odd partner as slaved. A one-cycle write strobe with the written channel number accompanies every update.

Top module: `chcfg_rx`

## Requirements
- R1: After reset every channel is single-ended with range code 0, and all invalid flags, all slave flags and `cfg_wr` are 0.
- R2: A data bit is taken only on a rising edge of `sclk` while `cs_n` is low. Edges while `cs_n` is high change nothing.
- R3: While the receiver is waiting for a byte, zero bits are skipped. The first one bit is the start bit, which is byte bit 7.
- R4: Byte layout, sent most significant bit first: bit 7 is the start bit, bits 6:4 are the channel, bit 3 is 1 for differential and 0 for single-ended, and bits 2:0 are the range code.
- R5: The byte is committed on the eighth bit counted from the start bit. `cfg_wr` is high for exactly one clock cycle, after the clock edge that detects that bit, and `cfg_wr_ch` gives the channel written.
- R6: If `cs_n` rises before the eighth bit, the partial byte is dropped and the table is unchanged.
- R7: After a commit the receiver waits for a new start bit, so one select frame may carry several bytes.
- R8: In single-ended mode codes 0 to 6 are valid and code 7 is invalid. The code is stored in every case, and `cfg_bad` of the written channel shows whether it is invalid.
- R9: In differential mode codes 0 to 2 are valid and codes 3 to 7 are invalid. The code is stored in every case and flagged as in R8.
- R10: A differential byte for channel c is written to channel c with bit 0 cleared, and `cfg_wr_ch` reports that even channel. The slave flag of the odd partner (c with bit 0 set) is set.
- R11: A single-ended byte for channel c writes only channel c and clears its slave flag. If c is even, it also clears the slave flag of c+1. No other channel changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| sdi | input | 1 | Serial data |
| cfg_diff | output | 8 | Differential flag per channel |
| cfg_range | output | 24 | Range code per channel, channel i in bits 3i+2:3i |
| cfg_bad | output | 8 | Invalid-range flag per channel |
| cfg_slave | output | 8 | Channel is the odd half of a differential pair |
| cfg_wr | output | 1 | One-cycle strobe on each committed byte |
| cfg_wr_ch | output | 3 | Channel written by the latest commit |

## Verification
The embedded properties check four things on every cycle. The table holds still while the select is high. A write strobe appears only after a cycle with the select low, and it never lasts two cycles. Every differential commit targets an even channel and leaves its odd partner flagged as slaved. The remaining behaviour needs the bench's scenarios, because it depends on sequence and content rather than on a single-cycle relation. This covers skipping of leading zeros, several bytes in one frame, dropping of truncated bytes, validity of each range code per mode, and slave flags being cleared by later single-ended writes.

// File: rtl/chcfg_rx.sv
module chcfg_rx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        sdi,
  output logic [7:0]  cfg_diff,
  output logic [23:0] cfg_range,
  output logic [7:0]  cfg_bad,
  output logic [7:0]  cfg_slave,
  output logic        cfg_wr,
  output logic [2:0]  cfg_wr_ch
);
  logic       sclk_q, busy, wr_diff;
  logic [2:0] cnt;
  logic [5:0] sr;

  wire       rise   = sclk & ~sclk_q & ~cs_n;
  wire       commit = rise & busy & (cnt == 3'd6);
  wire [6:0] word   = {sr, sdi};
  wire [2:0] ch     = word[6:4];
  wire       dif    = word[3];
  wire [2:0] rng    = word[2:0];
  wire       bad    = dif ? (rng > 3'd2) : (rng == 3'd7);
  wire [2:0] tgt    = dif ? {ch[2:1], 1'b0} : ch;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sr   <= '0;
    end else if (cs_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (rise) begin
      if (!busy) begin
        if (sdi) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else begin
        sr  <= {sr[4:0], sdi};
        cnt <= cnt + 3'd1;
        if (commit) busy <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_diff  <= '0;
      cfg_range <= '0;
      cfg_bad   <= '0;
      cfg_slave <= '0;
      cfg_wr    <= 1'b0;
      cfg_wr_ch <= '0;
      wr_diff   <= 1'b0;
    end else begin
      cfg_wr <= commit;
      if (commit) begin
        cfg_wr_ch            <= tgt;
        wr_diff              <= dif;
        cfg_diff[tgt]        <= dif;
        cfg_range[tgt*3 +: 3] <= rng;
        cfg_bad[tgt]         <= bad;
        if (dif) cfg_slave[{ch[2:1], 1'b1}] <= 1'b1;
        else begin
          cfg_slave[ch] <= 1'b0;
          if (!ch[0]) cfg_slave[{ch[2:1], 1'b1}] <= 1'b0;
        end
      end
    end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(cfg_range) && $stable(cfg_diff) && $stable(cfg_bad)));
  // R2
  wr_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> !$past(cs_n));
  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !cfg_wr);
  // R10
  diff_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && wr_diff) |-> (!cfg_wr_ch[0] && cfg_diff[cfg_wr_ch] && cfg_slave[cfg_wr_ch | 3'd1]));
endmodule

// File: tb/chcfg_rx_bench.sv
module chcfg_rx_bench;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic [7:0]  cfg_diff, cfg_bad, cfg_slave;
  logic [23:0] cfg_range;
  logic        cfg_wr;
  logic [2:0]  cfg_wr_ch;

  chcfg_rx u_chcfg_rx (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cfg_diff(cfg_diff), .cfg_range(cfg_range), .cfg_bad(cfg_bad), .cfg_slave(cfg_slave),
    .cfg_wr(cfg_wr), .cfg_wr_ch(cfg_wr_ch));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0]  m_diff = '0, m_bad = '0, m_slave = '0;
  logic [23:0] m_range = '0;
  logic prev_wr = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(cfg_diff == m_diff, req, "cfg_diff", cfg_diff, m_diff);
    chk(cfg_range == m_range, req, "cfg_range", cfg_range, m_range);
    chk(cfg_bad == m_bad, req, "cfg_bad", cfg_bad, m_bad);
    chk(cfg_slave == m_slave, req, "cfg_slave", cfg_slave, m_slave);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdi = b; sclk = 0;
    @(negedge clk); sclk = 1;
  endtask

  task automatic frame_begin();
    @(negedge clk); cs_n = 0; sclk = 0;
  endtask

  task automatic frame_end();
    @(negedge clk); sclk = 0; cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [2:0] ch, input logic dif, input logic [2:0] rng, input int zeros);
    logic [7:0] b;
    logic [2:0] tgt;
    logic bad;
    b   = {1'b1, ch, dif, rng};
    tgt = dif ? {ch[2:1], 1'b0} : ch;
    bad = dif ? (rng > 3'd2) : (rng == 3'd7);
    for (int i = 0; i < zeros; i++) send_bit(1'b0);
    for (int i = 7; i >= 1; i--) send_bit(b[i]);
    exp_q.push_back({tgt, dif, rng, bad});
    m_diff[tgt] = dif;
    m_range[tgt*3 +: 3] = rng;
    m_bad[tgt] = bad;
    if (dif) m_slave[{ch[2:1], 1'b1}] = 1'b1;
    else begin
      m_slave[ch] = 1'b0;
      if (!ch[0]) m_slave[{ch[2:1], 1'b1}] = 1'b0;
    end
    send_bit(b[0]);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (cfg_wr) begin
      chk(!prev_wr, "R5", "strobe longer than one cycle", 1, 0);
      if (exp_q.size() == 0) chk(0, "R6", "unexpected commit", cfg_wr_ch, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(cfg_wr_ch == e[7:5], "R4", "cfg_wr_ch", cfg_wr_ch, e[7:5]);
        chk(cfg_diff[e[7:5]] == e[4], "R4", "mode", cfg_diff[e[7:5]], e[4]);
        chk(cfg_range[e[7:5]*3 +: 3] == e[3:1], "R4", "range", cfg_range[e[7:5]*3 +: 3], e[3:1]);
        chk(cfg_bad[e[7:5]] == e[0], "R8 R9", "invalid flag", cfg_bad[e[7:5]], e[0]);
      end
    end
    prev_wr <= cfg_wr;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    chk(cfg_wr == 0, "R1", "cfg_wr", cfg_wr, 0);

    // R3 R7: leading zeros and two bytes in one frame
    frame_begin();
    send_byte(3'd3, 1'b0, 3'd5, 0);
    send_byte(3'd6, 1'b0, 3'd2, 3);
    frame_end();
    check_all("R7");

    // R2: sclk activity with select high is ignored
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    @(negedge clk); sclk = 0;
    repeat (2) @(negedge clk);
    check_all("R2");

    // R8: single-ended code 7 is stored and flagged
    frame_begin();
    send_byte(3'd1, 1'b0, 3'd7, 1);
    frame_end();
    check_all("R8");

    // R10 R9: differential pairs
    frame_begin();
    send_byte(3'd5, 1'b1, 3'd1, 2);
    send_byte(3'd2, 1'b1, 3'd4, 0);
    frame_end();
    check_all("R10");
    chk(cfg_slave[5] && cfg_slave[3], "R10", "slave flags", cfg_slave, 8'h28);

    // R11: single-ended writes dissolve slave flags
    frame_begin();
    send_byte(3'd4, 1'b0, 3'd0, 0);
    send_byte(3'd3, 1'b0, 3'd6, 4);
    frame_end();
    check_all("R11");

    // R6: truncated byte dropped
    frame_begin();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    frame_end();
    check_all("R6");
    // R6: the next frame starts fresh after a truncated one
    frame_begin();
    send_byte(3'd7, 1'b1, 3'd2, 0);
    frame_end();
    check_all("R6");

    // R3: frame of zeros only
    frame_begin();
    for (int i = 0; i < 12; i++) send_bit(1'b0);
    frame_end();
    check_all("R3");

    chk(exp_q.size() == 0, "R5", "missing commits", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule